// File: doc/BRIEF.md
# ADC result holding registers with completion flags

This block sits between an analog-to-digital converter and the system bus. Each time the converter finishes a sample, it presents a channel number, a 10-bit result and a one-cycle completion strobe. The block stores the result in that channel's data register and also in one global register, which additionally records the channel number. Both registers raise a completion flag. If burst mode is on and a result overwrites one that was never read, they also raise an overrun flag. Reading a register returns its contents and clears both of its flags.

The bus can also read and write an interrupt-enable register. One selector bit in that register chooses the interrupt source. With the selector at 1, the single interrupt line follows the global completion flag. With the selector at 0, the line follows the completion flags of the channels whose enable bits are set.

Top module: `adc_result_bank`

## Requirements
- R1: A channel data register reads with the result in bits 15:6, completion in bit 31 and overrun in bit 30; every other bit reads 0.
- R2: Read data appears on `bus_rdata` in the cycle after the read request. It shows the flags as they were before the read cleared them.
- R3: A completion strobe stores the result and sets the completion flag in the addressed channel register and in the global register.
- R4: Reading a register clears its completion and overrun flags and leaves the flags of every other register alone.
- R5: Overrun is set only when burst mode is on and a new result arrives while that register's completion flag is still 1. A repeated strobe without burst mode leaves overrun at 0.
- R6: The global register (address 8) holds the most recent result in bits 15:6 and its channel number in bits 26:24. Its flags are in bits 31 and 30, and it follows the same clear-on-read rule.
- R7: When interrupt-enable bit 8 is 1, `irq` is high exactly while the global completion flag is set.
- R8: When interrupt-enable bit 8 is 0, `irq` is high exactly while some channel n has its completion flag set and enable bit n (bits 7:0) set.
- R9: If a read and a new strobe hit the same register in the same cycle, the completion flag stays 1 and the overrun flag ends at 0.
- R10: The interrupt-enable register at address 9 is written with `bus_wdata` bits 8:0 and reads back in bits 8:0, with the upper bits at 0.
- R11: After reset, all flags are 0, the interrupt-enable register holds 0x100 and `irq` is low.
- R12: Addresses 0 to 7 select the channel registers. A read of any address above 9 returns 0 and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_valid | input | 1 | One-cycle completion strobe from the converter |
| conv_chan | input | 3 | Channel of the finished conversion |
| conv_data | input | 10 | Conversion result; 0 means near ground, 0x3FF means at or above the reference |
| burst_en | input | 1 | Burst mode; enables overrun detection |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request, used only for the interrupt-enable register |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 9 | Write data for the interrupt-enable register |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due one cycle after the read request. The bench therefore raises `bus_rd` just after a falling edge and samples `bus_rdata` at the next falling edge. That sample lands after the capturing rising edge and before any other edge. A strobe or a read changes the flags at one rising edge, and `irq` is decoded from those flags without a further register. The bench checks `irq` at the falling edge after the strobe or read, and this is also where flag clearing is observed through a later read. Same-cycle conflicts are driven in a single cycle, so the collision rule is tested at the exact edge where it applies.

// File: rtl/adc_res_pkg.sv
// Shared layout constants for the ADC result register block.
// Assumes a 32-bit bus word; all positions here are decoded by software.
package adc_res_pkg;
    localparam int DATA_LSB = 6;    // result field low bit
    localparam int CHAN_LSB = 24;   // channel field low bit in global register
    localparam int OVR_BIT  = 30;   // overrun flag
    localparam int DONE_BIT = 31;   // completion flag
    localparam int WORD_W   = 32;

    typedef struct packed {
        logic done;
        logic ovr;
    } flag_pair_t;
endpackage

// File: rtl/adc_flag_slot.sv
// One result holder with completion and overrun flags.
// Assumes load and clr may arrive in the same cycle; load then wins for
// completion and overrun ends cleared. Overrun needs burst mode.
module adc_flag_slot #(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          burst,
    input  logic          clr,
    input  logic [PW-1:0] din,
    output adc_res_pkg::flag_pair_t flags,
    output logic [PW-1:0] dout
);
    // Payload capture on each completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end

    // Completion flag: set by load, cleared by read, load dominates.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags.done <= 1'b0;
        else if (load)
            flags.done <= 1'b1;
        else if (clr)
            flags.done <= 1'b0;
    end

    // Overrun flag: burst overwrite of unread data, cleared by read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags.ovr <= 1'b0;
        else if (load && burst && flags.done && !clr)
            flags.ovr <= 1'b1;
        else if (clr)
            flags.ovr <= 1'b0;
    end
endmodule

// File: rtl/adc_irq_select.sv
// Interrupt-enable register and request selection.
// Bit NCH selects global completion; bits NCH-1:0 gate channel flags.
// Assumes reset value enables only the global source.
module adc_irq_select #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_wr,
    input  logic [NCH:0]   en_wdata,
    input  logic [NCH-1:0] ch_done,
    input  logic           g_done,
    output logic [NCH:0]   en_q,
    output logic           irq
);
    localparam logic [NCH:0] EN_RESET = {1'b1, {NCH{1'b0}}};

    // Enable register write path.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= EN_RESET;
        else if (en_wr)
            en_q <= en_wdata;
    end

    // Source selection for the request line.
    always_comb begin
        if (en_q[NCH])
            irq = g_done;
        else
            irq = |(ch_done & en_q[NCH-1:0]);
    end
endmodule

// File: rtl/adc_result_bank.sv
// Top of the ADC result register block: per-channel slots, a global slot,
// the interrupt selector and a registered read port with clear-on-read.
// Assumes one bus access per cycle; read data is returned one cycle later.
module adc_result_bank #(
    parameter int NCH = 8,
    parameter int RW  = 10,
    parameter int AW  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   conv_valid,
    input  logic [$clog2(NCH)-1:0] conv_chan,
    input  logic [RW-1:0]          conv_data,
    input  logic                   burst_en,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [AW-1:0]          bus_addr,
    input  logic [NCH:0]           bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic                   irq
);
    import adc_res_pkg::*;

    localparam int CHW = $clog2(NCH);
    localparam int GPW = RW + CHW;
    localparam logic [AW-1:0] GLB_ADDR = AW'(NCH);
    localparam logic [AW-1:0] EN_ADDR  = AW'(NCH + 1);

    flag_pair_t           ch_flags [NCH];
    logic [RW-1:0]        ch_res   [NCH];
    logic [NCH-1:0]       ch_done;
    flag_pair_t           g_flags;
    logic [GPW-1:0]       g_pay;
    logic [NCH:0]         en_q;
    logic                 g_clr;
    logic [WORD_W-1:0]    rd_word;

    assign g_clr = bus_rd && (bus_addr == GLB_ADDR);

    // Per-channel result slots.
    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic ld_k;
        logic clr_k;
        assign ld_k  = conv_valid && (conv_chan == CHW'(k));
        assign clr_k = bus_rd && (bus_addr == AW'(k));
        adc_flag_slot #(.PW(RW)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (ld_k),
            .burst (burst_en),
            .clr   (clr_k),
            .din   (conv_data),
            .flags (ch_flags[k]),
            .dout  (ch_res[k])
        );
        assign ch_done[k] = ch_flags[k].done;
    end

    // Global slot holding latest result and its channel.
    adc_flag_slot #(.PW(GPW)) u_glb (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (conv_valid),
        .burst (burst_en),
        .clr   (g_clr),
        .din   ({conv_chan, conv_data}),
        .flags (g_flags),
        .dout  (g_pay)
    );

    adc_irq_select #(.NCH(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (bus_wr && (bus_addr == EN_ADDR)),
        .en_wdata (bus_wdata),
        .ch_done  (ch_done),
        .g_done   (g_flags.done),
        .en_q     (en_q),
        .irq      (irq)
    );

    // Read word assembly from the addressed register.
    always_comb begin
        rd_word = '0;
        if (bus_addr == GLB_ADDR) begin
            rd_word[DONE_BIT]            = g_flags.done;
            rd_word[OVR_BIT]             = g_flags.ovr;
            rd_word[CHAN_LSB +: CHW]     = g_pay[RW +: CHW];
            rd_word[DATA_LSB +: RW]      = g_pay[RW-1:0];
        end else if (bus_addr == EN_ADDR) begin
            rd_word[NCH:0]               = en_q;
        end else begin
            for (int k = 0; k < NCH; k++) begin
                if (bus_addr == AW'(k)) begin
                    rd_word[DONE_BIT]       = ch_flags[k].done;
                    rd_word[OVR_BIT]        = ch_flags[k].ovr;
                    rd_word[DATA_LSB +: RW] = ch_res[k];
                end
            end
        end
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_word;
    end
endmodule

// File: rtl/adc_result_chk.sv
// Property checker for adc_result_bank, attached by bind below.
module adc_result_chk #(
    parameter int NCH = 8,
    parameter int AW  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   conv_valid,
    input logic                   burst_en,
    input logic                   bus_rd,
    input logic [AW-1:0]          bus_addr,
    input logic                   g_done,
    input logic                   g_ovr,
    input logic                   gsel,
    input logic                   irq
);
    // R3: any completion sets the global flag on the next cycle.
    a_r3_glb_set: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> g_done);

    // R4: a global read with no strobe clears both global flags.
    a_r4_glb_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == AW'(NCH) && !conv_valid) |=> (!g_done && !g_ovr));

    // R5: overrun can only rise after a burst-mode cycle.
    a_r5_ovr_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_ovr) |-> $past(burst_en));

    // R7: with global selection, a falling global flag drops the request.
    a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(g_done) && gsel && $past(gsel)) |-> !irq);

    // R9: read colliding with a strobe keeps completion and clears overrun.
    a_r9_collide: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid && bus_rd && bus_addr == AW'(NCH)) |=> (g_done && !g_ovr));
endmodule

bind adc_result_bank adc_result_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .burst_en   (burst_en),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .g_done     (g_flags.done),
    .g_ovr      (g_flags.ovr),
    .gsel       (en_q[NCH]),
    .irq        (irq)
);

// File: tb/sim_adc_result_bank.sv
module sim_adc_result_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [2:0]  conv_chan = '0;
    logic [9:0]  conv_data = '0;
    logic        burst_en = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [8:0]  bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    adc_result_bank u0 (.*);

    function automatic logic [31:0] word(input logic d, input logic o,
                                         input logic [2:0] ch, input logic [9:0] r);
        return {d, o, 3'b0, ch, 8'b0, r, 6'b0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic conv(input logic [2:0] ch, input logic [9:0] d);
        @(negedge clk);
        conv_valid = 1'b1; conv_chan = ch; conv_data = d;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr_en(input logic [8:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd9; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R11 irq after reset", {31'b0, irq}, 32'd0);
        rd(4'd9, d); chk("R11 enable reset", d, 32'h100);
        rd(4'd0, d); chk("R11 ch0 flags clear", d, 32'd0);
        rd(4'd8, d); chk("R11 global clear", d, 32'd0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        burst_en = 1'b0;
        conv(3'd3, 10'h2AB);
        chk("R7 irq on global done", {31'b0, irq}, 32'd1);
        rd(4'd3, d); chk("R1 R3 ch3 word", d, word(1, 0, 0, 10'h2AB));
        chk("R7 irq holds until global read", {31'b0, irq}, 32'd1);
        rd(4'd8, d); chk("R6 global word", d, word(1, 0, 3'd3, 10'h2AB));
        chk("R7 irq drops after global read", {31'b0, irq}, 32'd0);
        rd(4'd3, d); chk("R4 ch3 cleared", d, word(0, 0, 0, 10'h2AB));
    endtask

    task automatic t_overrun;
        logic [31:0] d;
        burst_en = 1'b1;
        conv(3'd5, 10'h3FF);
        conv(3'd5, 10'h001);
        rd(4'd5, d); chk("R5 burst overrun ch5", d, word(1, 1, 0, 10'h001));
        rd(4'd5, d); chk("R2 R4 overrun cleared", d, word(0, 0, 0, 10'h001));
        rd(4'd8, d); chk("R6 global overrun", d, word(1, 1, 3'd5, 10'h001));
        burst_en = 1'b0;
        conv(3'd2, 10'h010);
        conv(3'd2, 10'h020);
        rd(4'd2, d); chk("R5 no overrun without burst", d, word(1, 0, 0, 10'h020));
        rd(4'd8, d); chk("R5 global no overrun", d, word(1, 0, 3'd2, 10'h020));
    endtask

    task automatic t_chan_irq;
        logic [31:0] d;
        wr_en(9'h004);
        rd(4'd9, d); chk("R10 enable readback", d, 32'h004);
        conv(3'd1, 10'h111);
        chk("R8 unmasked channel no irq", {31'b0, irq}, 32'd0);
        conv(3'd2, 10'h222);
        chk("R8 enabled channel irq", {31'b0, irq}, 32'd1);
        rd(4'd1, d); chk("R4 ch1 read", d, word(1, 0, 0, 10'h111));
        chk("R4 R8 other read keeps irq", {31'b0, irq}, 32'd1);
        rd(4'd2, d);
        chk("R8 irq drops after ch2 read", {31'b0, irq}, 32'd0);
        rd(4'd8, d);
        wr_en(9'h100);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        burst_en = 1'b1;
        conv(3'd4, 10'h100);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'd4;
        conv_valid = 1'b1; conv_chan = 3'd4; conv_data = 10'h0AA;
        @(negedge clk);
        bus_rd = 1'b0; conv_valid = 1'b0;
        chk("R2 R9 pre-clear data", bus_rdata, word(1, 0, 0, 10'h100));
        rd(4'd4, d); chk("R9 done kept overrun clear", d, word(1, 0, 0, 10'h0AA));
        rd(4'd8, d);
        burst_en = 1'b0;
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        conv(3'd7, 10'h155);
        rd(4'd12, d); chk("R12 unmapped read zero", d, 32'd0);
        rd(4'd7, d); chk("R12 flags untouched by unmapped read", d, word(1, 0, 0, 10'h155));
        rd(4'd8, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_overrun;
        t_chan_irq;
        t_collide;
        t_unmapped;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule